// File: doc/BRIEF.md
# Display Frame Format Latch

This block turns the raw display configuration registers into a compact descriptor of the frame about to be shown. Each time the frame-latch strobe is high at a rising clock edge, it decodes the packed size word, the colour mode, the enable and interlace controls, the blanking control, the border colour and the base address. From these it produces the horizontal resolution in pixels, the vertical resolution in lines, the pixel format, the row stride in bytes, the base address, and the enable and blank state. All of these are registered and then held until the next strobe.

The horizontal resolution is derived from a count of 32-bit words per line, and the colour mode sets the conversion. Packed 24-bit pixels need a divide by three. The block keeps two format slots that it fills alternately on enabled frames. It pulses a change strobe when a new frame's resolution or format differs from the slot not being written, which is the previous enabled frame. A disabled frame resets the slot index and pulses a disabled strobe. A blanked frame pulses a blank strobe that carries the border colour. Downstream display logic uses the change strobe to reprogram its timing, and uses the blank strobe to fill the screen with the border colour.

Top module: `dfl_latch`

## Requirements
- R1: The size word packs three 10-bit fields. Bits 9:0 hold words per line minus one, bits 19:10 hold lines per field minus one, and bits 29:20 hold the row modulo. The block uses words per line = field+1 and lines = field+1.
- R2: The pixel format output equals mode bits 3:2. Horizontal resolution is 2×words for formats 0 and 1, (4×words)/3 rounded down for format 2, and words for format 3.
- R3: The row stride in bytes is (words-per-line field + modulo field) × 4. This is the same as (words + modulo − 1) × 4.
- R4: Vertical resolution equals lines per field. It is doubled when config bit 4 (interlace) is set.
- R5: A frame is enabled only when mode bit 0 (display enable) and config bit 3 (video out) are both set. A frame that is not enabled drives enabled_o low and pulses off_stb_o.
- R6: A disabled frame returns the slot index to 0 and clears slot 0's resolutions to zero. It reports slot_o = 0, and the next enabled frame is written into slot 0.
- R7: Enabled frames alternate between slot 0 and slot 1. slot_o reports the slot written by the current frame.
- R8: On an enabled frame, change_stb_o pulses when hres, vres or format differs from the other slot's stored values. After reset, both slots hold zero resolution and format 0.
- R9: On an enabled frame with secondary config bit 3 set, blank_stb_o pulses, blank_o goes high and border_o carries the border colour. blank_stb_o never pulses on a disabled frame.
- R10: The descriptor outputs (hres_o, vres_o, fmt_o, stride_o, base_o, enabled_o, blank_o, slot_o, border_o) change only in the cycle after a latch strobe. base_o takes the base address.
- R11: change_stb_o, blank_stb_o and off_stb_o are high for exactly the one cycle that follows a latch strobe. They stay low in every cycle that does not follow a latch strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| latch_i | input | 1 | Frame-latch strobe |
| size_i | input | 32 | Packed size word (modulo, lines, words) |
| mode_i | input | 32 | Mode register: bit 0 enable, bits 3:2 format |
| cfg_i | input | 32 | Config register: bit 3 video out, bit 4 interlace |
| cfg2_i | input | 32 | Secondary config: bit 3 blank |
| border_i | input | 24 | Border colour |
| base_i | input | 24 | Frame base address |
| hres_o | output | 12 | Horizontal resolution in pixels |
| vres_o | output | 12 | Vertical resolution in lines |
| fmt_o | output | 2 | Pixel format code |
| stride_o | output | 13 | Row stride in bytes |
| base_o | output | 24 | Latched base address |
| enabled_o | output | 1 | Frame enabled |
| blank_o | output | 1 | Frame blanked |
| slot_o | output | 1 | Slot written by this frame |
| border_o | output | 24 | Latched border colour |
| change_stb_o | output | 1 | Format-change pulse |
| blank_stb_o | output | 1 | Blank pulse |
| off_stb_o | output | 1 | Disabled-frame pulse |

## Verification
Some properties are checked on every cycle. The strobes stay silent without a preceding latch, and the descriptor holds steady between latches. The enable flag follows the two control bits, a blank strobe implies an enabled and blanked frame, and a disabled frame reports slot 0. The vertical resolution is also checked for progressive frames. Other behaviour needs the bench's reference model over a sequence of frames. This covers the exact resolution arithmetic, including the divide by three, and the alternation of slots. It also covers change detection against the other slot, and the clearing of slot 0 after a disabled frame.

// File: rtl/dfl_pkg.sv
package dfl_pkg;
  // control bit positions inside the configuration words
  localparam int MODE_EN_BIT    = 0;
  localparam int MODE_FMT_LSB   = 2;
  localparam int CFG_VOUT_BIT   = 3;
  localparam int CFG_ILACE_BIT  = 4;
  localparam int CFG2_BLANK_BIT = 3;

  typedef enum logic [1:0] {
    FMT_ARGB1555 = 2'd0,
    FMT_RGB565   = 2'd1,
    FMT_RGB888P  = 2'd2,
    FMT_ARGB8888 = 2'd3
  } pix_fmt_e;
endpackage

// File: rtl/dfl_decode.sv
module dfl_decode
  import dfl_pkg::*;
#(
  parameter int FLD_W = 10,
  localparam int RES_W = FLD_W + 2,
  localparam int STRIDE_W = FLD_W + 3
) (
  input  logic [FLD_W-1:0]    words_m1_i,
  input  logic [FLD_W-1:0]    lines_m1_i,
  input  logic [FLD_W-1:0]    modulo_i,
  input  pix_fmt_e            fmt_i,
  input  logic                ilace_i,
  output logic [RES_W-1:0]    hres_o,
  output logic [RES_W-1:0]    vres_o,
  output logic [STRIDE_W-1:0] stride_o
);
  logic [FLD_W:0]   words;
  logic [FLD_W:0]   lines;
  logic [FLD_W:0]   row_sum;
  logic [RES_W:0]   words_x4;
  logic [RES_W:0]   packed_px;

  always_comb begin
    words     = {1'b0, words_m1_i} + 1'b1;
    lines     = {1'b0, lines_m1_i} + 1'b1;
    row_sum   = {1'b0, words_m1_i} + {1'b0, modulo_i};
    words_x4  = {words, 2'b00};
    packed_px = words_x4 / 3;
    case (fmt_i)
      FMT_ARGB1555, FMT_RGB565: hres_o = {words, 1'b0};
      FMT_RGB888P:              hres_o = packed_px[RES_W-1:0];
      default:                  hres_o = {1'b0, words};
    endcase
    vres_o   = ilace_i ? {lines, 1'b0} : {1'b0, lines};
    stride_o = {row_sum, 2'b00};
  end
endmodule

// File: rtl/dfl_slots.sv
module dfl_slots
  import dfl_pkg::*;
#(
  parameter int RES_W = 12,
  localparam int NSLOT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic             clr_i,
  input  logic [RES_W-1:0] hres_i,
  input  logic [RES_W-1:0] vres_i,
  input  pix_fmt_e         fmt_i,
  output logic             idx_o,
  output logic             diff_o
);
  logic [RES_W-1:0] hres_q [NSLOT];
  logic [RES_W-1:0] vres_q [NSLOT];
  pix_fmt_e         fmt_q  [NSLOT];
  logic             idx_q;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        hres_q[s] <= '0;
        vres_q[s] <= '0;
        fmt_q[s]  <= FMT_ARGB1555;
      end else if (wr_i && (idx_q == 1'(s))) begin
        hres_q[s] <= hres_i;
        vres_q[s] <= vres_i;
        fmt_q[s]  <= fmt_i;
      end else if (clr_i && (s == 0)) begin
        hres_q[s] <= '0;
        vres_q[s] <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        idx_q <= 1'b0;
    else if (clr_i) idx_q <= 1'b0;
    else if (wr_i)  idx_q <= ~idx_q;
  end

  assign idx_o  = idx_q;
  assign diff_o = (hres_i != hres_q[~idx_q]) || (vres_i != vres_q[~idx_q]) ||
                  (fmt_i != fmt_q[~idx_q]);
endmodule

// File: rtl/dfl_latch.sv
module dfl_latch
  import dfl_pkg::*;
#(
  parameter int FLD_W  = 10,
  parameter int REG_W  = 32,
  parameter int ADDR_W = 24,
  parameter int COL_W  = 24,
  localparam int RES_W    = FLD_W + 2,
  localparam int STRIDE_W = FLD_W + 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                latch_i,
  input  logic [REG_W-1:0]    size_i,
  input  logic [REG_W-1:0]    mode_i,
  input  logic [REG_W-1:0]    cfg_i,
  input  logic [REG_W-1:0]    cfg2_i,
  input  logic [COL_W-1:0]    border_i,
  input  logic [ADDR_W-1:0]   base_i,
  output logic [RES_W-1:0]    hres_o,
  output logic [RES_W-1:0]    vres_o,
  output logic [1:0]          fmt_o,
  output logic [STRIDE_W-1:0] stride_o,
  output logic [ADDR_W-1:0]   base_o,
  output logic                enabled_o,
  output logic                blank_o,
  output logic                slot_o,
  output logic [COL_W-1:0]    border_o,
  output logic                change_stb_o,
  output logic                blank_stb_o,
  output logic                off_stb_o
);
  pix_fmt_e            fmt;
  logic                en, blank_req;
  logic [RES_W-1:0]    hres_d, vres_d;
  logic [STRIDE_W-1:0] stride_d;
  logic                slot_idx, slot_diff;
  logic                unused_bits;

  assign fmt       = pix_fmt_e'(mode_i[MODE_FMT_LSB +: 2]);
  assign en        = mode_i[MODE_EN_BIT] & cfg_i[CFG_VOUT_BIT];
  assign blank_req = cfg2_i[CFG2_BLANK_BIT];
  assign unused_bits = ^{size_i[REG_W-1:3*FLD_W], mode_i[REG_W-1:4], mode_i[1],
                         cfg_i[REG_W-1:5], cfg_i[2:0], cfg2_i[REG_W-1:4], cfg2_i[2:0]};

  dfl_decode #(.FLD_W(FLD_W)) dec_i (
    .words_m1_i (size_i[FLD_W-1:0]),
    .lines_m1_i (size_i[2*FLD_W-1:FLD_W]),
    .modulo_i   (size_i[3*FLD_W-1:2*FLD_W]),
    .fmt_i      (fmt),
    .ilace_i    (cfg_i[CFG_ILACE_BIT]),
    .hres_o     (hres_d),
    .vres_o     (vres_d),
    .stride_o   (stride_d)
  );

  dfl_slots #(.RES_W(RES_W)) slots_i (
    .clk    (clk),
    .rst    (rst),
    .wr_i   (latch_i & en),
    .clr_i  (latch_i & ~en),
    .hres_i (hres_d),
    .vres_i (vres_d),
    .fmt_i  (fmt),
    .idx_o  (slot_idx),
    .diff_o (slot_diff)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hres_o    <= '0;
      vres_o    <= '0;
      fmt_o     <= '0;
      stride_o  <= '0;
      base_o    <= '0;
      enabled_o <= 1'b0;
      blank_o   <= 1'b0;
      slot_o    <= 1'b0;
      border_o  <= '0;
    end else if (latch_i) begin
      hres_o    <= hres_d;
      vres_o    <= vres_d;
      fmt_o     <= fmt;
      stride_o  <= stride_d;
      base_o    <= base_i;
      enabled_o <= en;
      blank_o   <= en & blank_req;
      slot_o    <= en & slot_idx;
      border_o  <= border_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      change_stb_o <= 1'b0;
      blank_stb_o  <= 1'b0;
      off_stb_o    <= 1'b0;
    end else begin
      change_stb_o <= latch_i & en & slot_diff;
      blank_stb_o  <= latch_i & en & blank_req;
      off_stb_o    <= latch_i & ~en;
    end
  end
endmodule

// File: rtl/dfl_latch_chk.sv
module dfl_latch_chk #(
  parameter int FLD_W  = 10,
  parameter int REG_W  = 32,
  parameter int ADDR_W = 24,
  localparam int RES_W    = FLD_W + 2,
  localparam int STRIDE_W = FLD_W + 3
) (
  input logic                clk,
  input logic                rst,
  input logic                latch_i,
  input logic [REG_W-1:0]    size_i,
  input logic [REG_W-1:0]    mode_i,
  input logic [REG_W-1:0]    cfg_i,
  input logic [RES_W-1:0]    hres_o,
  input logic [RES_W-1:0]    vres_o,
  input logic [STRIDE_W-1:0] stride_o,
  input logic [ADDR_W-1:0]   base_o,
  input logic                enabled_o,
  input logic                blank_o,
  input logic                slot_o,
  input logic                change_stb_o,
  input logic                blank_stb_o,
  input logic                off_stb_o
);
  p_quiet_strobes_r11: assert property (@(posedge clk) disable iff (rst)
    !latch_i |=> (!change_stb_o && !blank_stb_o && !off_stb_o));

  p_hold_desc_r10: assert property (@(posedge clk) disable iff (rst)
    !latch_i |=> ($stable(hres_o) && $stable(vres_o) && $stable(stride_o) &&
                  $stable(base_o) && $stable(enabled_o) && $stable(slot_o)));

  p_enable_rule_r5: assert property (@(posedge clk) disable iff (rst)
    latch_i |=> (enabled_o == ($past(mode_i[0]) && $past(cfg_i[3]))));

  p_off_flag_r5: assert property (@(posedge clk) disable iff (rst)
    off_stb_o |-> !enabled_o);

  p_off_slot_r6: assert property (@(posedge clk) disable iff (rst)
    off_stb_o |-> (slot_o == 1'b0));

  p_blank_only_enabled_r9: assert property (@(posedge clk) disable iff (rst)
    blank_stb_o |-> (enabled_o && blank_o));

  p_vres_prog_r4: assert property (@(posedge clk) disable iff (rst)
    (latch_i && !cfg_i[4]) |=>
      (vres_o == RES_W'({1'b0, $past(size_i[2*FLD_W-1:FLD_W])} + 1'b1)));
endmodule

bind dfl_latch dfl_latch_chk #(.FLD_W(FLD_W), .REG_W(REG_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .latch_i(latch_i), .size_i(size_i), .mode_i(mode_i),
  .cfg_i(cfg_i), .hres_o(hres_o), .vres_o(vres_o), .stride_o(stride_o),
  .base_o(base_o), .enabled_o(enabled_o), .blank_o(blank_o), .slot_o(slot_o),
  .change_stb_o(change_stb_o), .blank_stb_o(blank_stb_o), .off_stb_o(off_stb_o)
);

// File: tb/dfl_latch_tb.sv
module dfl_latch_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        latch_i = 1'b0;
  logic [31:0] size_i = '0, mode_i = '0, cfg_i = '0, cfg2_i = '0;
  logic [23:0] border_i = '0, base_i = '0;
  logic [11:0] hres_o, vres_o;
  logic [1:0]  fmt_o;
  logic [12:0] stride_o;
  logic [23:0] base_o, border_o;
  logic        enabled_o, blank_o, slot_o, change_stb_o, blank_stb_o, off_stb_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  // reference model state
  int m_h [2];
  int m_v [2];
  int m_f [2];
  int m_idx;

  always #5 clk = ~clk;

  dfl_latch dut_i (
    .clk(clk), .rst(rst), .latch_i(latch_i), .size_i(size_i), .mode_i(mode_i),
    .cfg_i(cfg_i), .cfg2_i(cfg2_i), .border_i(border_i), .base_i(base_i),
    .hres_o(hres_o), .vres_o(vres_o), .fmt_o(fmt_o), .stride_o(stride_o),
    .base_o(base_o), .enabled_o(enabled_o), .blank_o(blank_o), .slot_o(slot_o),
    .border_o(border_o), .change_stb_o(change_stb_o), .blank_stb_o(blank_stb_o),
    .off_stb_o(off_stb_o)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int exp_hres(input int fmt, input int wraw);
    int w = wraw + 1;
    case (fmt)
      0, 1: return 2 * w;
      2: return (4 * w) / 3;
      default: return w;
    endcase
  endfunction

  function automatic logic [31:0] mk_size(input int m, input int l, input int w);
    return {2'b00, 10'(m), 10'(l), 10'(w)};
  endfunction

  // one frame: drive, latch, compare against the model
  task automatic frame(input int m, input int l, input int w, input int fmt, input bit de,
                       input bit vo, input bit il, input bit bl, input int bord, input int base);
    int eh, ev, ed;
    bit en;
    @(negedge clk);
    size_i   = mk_size(m, l, w);
    mode_i   = {$urandom} & 32'hFFFF_FFF2 | {28'd0, 2'(fmt), 1'b0, de};
    cfg_i    = {$urandom} & 32'hFFFF_FFE7 | {27'd0, il, vo, 3'd0};
    cfg2_i   = {$urandom} & 32'hFFFF_FFF7 | {28'd0, bl, 3'd0};
    border_i = 24'(bord);
    base_i   = 24'(base);
    latch_i  = 1'b1;
    @(negedge clk);
    latch_i  = 1'b0;
    en = de && vo;
    eh = exp_hres(fmt, w);
    ev = il ? 2 * (l + 1) : l + 1;
    chk("R2 hres", hres_o, eh);
    chk("R2 fmt", fmt_o, fmt);
    chk("R1/R4 vres", vres_o, ev);
    chk("R3 stride", stride_o, (w + m) * 4);
    chk("R10 base", base_o, base);
    chk("R5 enabled", enabled_o, en);
    chk("R5 off strobe", off_stb_o, !en);
    chk("R9 blank strobe", blank_stb_o, en && bl);
    chk("R9 blank level", blank_o, en && bl);
    chk("R9 border", border_o, bord);
    if (en) begin
      ed = (eh != m_h[1 - m_idx]) || (ev != m_v[1 - m_idx]) || (fmt != m_f[1 - m_idx]);
      chk("R7 slot", slot_o, m_idx);
      chk("R8 change", change_stb_o, ed);
      m_h[m_idx] = eh; m_v[m_idx] = ev; m_f[m_idx] = fmt;
      m_idx = 1 - m_idx;
    end else begin
      chk("R6 slot on off", slot_o, 0);
      chk("R8 no change when off", change_stb_o, 0);
      m_idx = 0; m_h[0] = 0; m_v[0] = 0;
    end
  endtask

  // inputs move without a latch: outputs hold, strobes drop
  task automatic idle_hold();
    int h, v, s, b;
    h = hres_o; v = vres_o; s = stride_o; b = base_o;
    @(negedge clk);
    size_i = $urandom; mode_i = $urandom; cfg_i = $urandom; base_i = 24'($urandom);
    @(negedge clk);
    chk("R10 hres hold", hres_o, h);
    chk("R10 vres hold", vres_o, v);
    chk("R10 stride hold", stride_o, s);
    chk("R10 base hold", base_o, b);
    chk("R11 change pulse", change_stb_o, 0);
    chk("R11 blank pulse", blank_stb_o, 0);
    chk("R11 off pulse", off_stb_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_h = '{0, 0}; m_v = '{0, 0}; m_f = '{0, 0}; m_idx = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 reset hres", hres_o, 0);
    chk("R10 reset enabled", enabled_o, 0);
    chk("R11 reset strobes", change_stb_o | blank_stb_o | off_stb_o, 0);

    // directed corner cases
    frame(1, 479, 639, 3, 1, 1, 0, 0, 24'h123456, 24'h000100); // R8 first change
    frame(1, 479, 639, 3, 1, 1, 0, 0, 24'h0, 24'h000200);      // R7 slot 1, same
    frame(1, 479, 639, 3, 1, 1, 0, 0, 24'h0, 24'h000300);      // R7 slot 0, same
    frame(1, 479, 319, 1, 1, 1, 0, 0, 24'h0, 24'h000400);      // R8 format change
    idle_hold();
    frame(0, 239, 0, 2, 1, 1, 1, 0, 24'h0, 24'h000500);        // R2 div3 of 4 -> 1
    frame(0, 1023, 1023, 0, 1, 1, 1, 1, 24'hABCDEF, 24'hFFFFFF); // R2/R4 max, R9
    frame(1023, 10, 1023, 2, 1, 0, 0, 1, 24'h111111, 24'h0);   // R5 vo off, R9 no blank
    frame(5, 10, 20, 3, 0, 1, 0, 0, 24'h0, 24'h0);             // R5 de off
    frame(5, 10, 20, 3, 1, 1, 0, 0, 24'h0, 24'h0);             // R6 restart slot 0
    frame(5, 10, 20, 3, 1, 1, 0, 0, 24'h0, 24'h0);             // R6 slot 1
    idle_hold();

    // constrained random frames
    for (int i = 0; i < 400; i++) begin
      frame(int'($urandom_range(0, 1023)), int'($urandom_range(0, 3)) * 100 + 99,
            int'($urandom_range(0, 3)) * 160 + 159, int'($urandom_range(0, 3)),
            ($urandom_range(0, 9) != 0), ($urandom_range(0, 9) != 0),
            1'($urandom), ($urandom_range(0, 3) == 0),
            int'($urandom & 32'hFFFFFF), int'($urandom & 32'hFFFFFF));
      if (i % 37 == 0) idle_hold();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule